// File: doc/BRIEF.md
# Single-Cycle RISC Integer Execute Unit

This block takes one 32-bit instruction word per clock from a fixed-format, three-operand integer instruction subset. It decodes the word, reads two source operands from an internal 32 x 32-bit register file, computes the result and writes it back at the next rising clock edge. The next word can use that result at once.

The unit covers three groups of work:
- register-register arithmetic and logic;
- immediate arithmetic and logic;
- signed and unsigned set-on-less-than, zero-filling shifts by a constant, and equal / not-equal branch tests.

The surrounding fetch logic reads two outputs. One reports whether a branch condition held. The other reports whether the word was not recognised. The write-back bus (enable, destination index, value) is also brought out, so that a fetch or trace stage can observe each result.

Computing branch targets, memory access and jumps belong to neighbouring stages. A word is presented together with a valid strobe. Every valid word completes in one cycle.

Top module: `intExecUnit`

## Requirements
- R1: Register-format words are split from bit 31 down into opcode[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. With opcode 0, funct 32 adds and funct 34 subtracts (rs minus rt). Both wrap modulo 2^32, and the result goes to rd (for example 0x02324020 writes r17+r18 into r8).
- R2: With opcode 0, funct 36 gives rs AND rt, funct 37 gives rs OR rt and funct 39 gives NOT(rs OR rt). NOR with r0 as the second operand gives the bitwise inverse.
- R3: Immediate words hold opcode[31:26], rs[25:21], rt[20:16] and imm[15:0], and the destination is rt. Opcode 8 (add), 10 (signed less-than) and 11 (unsigned less-than) sign-extend imm. Opcode 12 (AND) and 13 (OR) zero-extend it.
- R4: Register 0 always reads as zero. A write aimed at it is dropped, and wbEn stays low for it.
- R5: Funct 42 and opcode 10 compare as two's-complement numbers. Funct 43 and opcode 11 compare as unsigned numbers. The result is exactly 1 or 0.
- R6: Funct 0 shifts rt left and funct 2 shifts rt right by shamt places. Both fill with zeros, and shamt 0 passes rt unchanged.
- R7: Opcode 4 raises branchTaken when rs equals rt. Opcode 5 raises it when they differ. Neither writes a register.
- R8: Any other opcode, or any other funct under opcode 0, raises illegalInstr. Such a word writes no register and raises no branch.
- R9: Reset clears every register to zero. While instrValid is low, wbEn, branchTaken and illegalInstr are all low.
- R10: The write lands at the rising edge that ends the instruction's cycle. The very next word reads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes happen on its rising edge |
| rstN | input | 1 | Active-low synchronous reset; clears the register file |
| instrValid | input | 1 | The instruction word is valid this cycle |
| instrWord | input | 32 | Instruction word to execute |
| branchTaken | output | 1 | Branch condition of the current word holds |
| illegalInstr | output | 1 | Current word is not recognised |
| wbEn | output | 1 | A register will be written at the coming edge |
| wbAddr | output | 5 | Destination register index |
| wbData | output | 32 | Computed result (ALU output) |

## Verification
The bench focuses on operands where a subtle slip changes the answer:
- The pair 0xFFFFFFFF and 1 separates the two comparisons. A design that shares one comparator for both forms returns the same answer for slt and sltu on it.
- An immediate with bit 15 set separates the two extensions. A design that mixes up sign- and zero-extension makes andi and ori return 0xFFFF_xxxx, or makes addi return a small positive value.
- Writes to r0, and unrecognised funct codes that name a live destination, are followed by read-backs. These expose a register file that keeps the stray value.
- Shifts by 0 and by 31, and back-to-back dependent words, catch an arithmetic fill and a one-cycle-late write.

// File: rtl/execPkg.sv
package execPkg;

  typedef enum logic [3:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_NOR,
    ALU_SLT,
    ALU_SLTU,
    ALU_SLL,
    ALU_SRL
  } aluOpE;

  // strobes from control to datapath
  typedef struct packed {
    aluOpE aluOp;
    logic  useImm;
    logic  immZero;
    logic  regWrite;
    logic  isBranch;
    logic  branchNe;
  } ctrlStrobesT;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_BNE   = 6'd5;
  localparam logic [5:0] OPC_ADDI  = 6'd8;
  localparam logic [5:0] OPC_SLTI  = 6'd10;
  localparam logic [5:0] OPC_SLTIU = 6'd11;
  localparam logic [5:0] OPC_ANDI  = 6'd12;
  localparam logic [5:0] OPC_ORI   = 6'd13;

  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_SRL  = 6'd2;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_NOR  = 6'd39;
  localparam logic [5:0] FN_SLT  = 6'd42;
  localparam logic [5:0] FN_SLTU = 6'd43;

endpackage

// File: rtl/execRegFile.sv
module execRegFile #(
  parameter int DATA_W   = 32,
  parameter int REG_CNT  = 32,
  parameter int RD_PORTS = 2,
  localparam int REG_AW  = $clog2(REG_CNT)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                wrEn,
  input  logic [REG_AW-1:0]                   wrAddr,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [RD_PORTS-1:0][REG_AW-1:0]     rdAddr,
  output logic [RD_PORTS-1:0][DATA_W-1:0]     rdData
);

  logic [DATA_W-1:0] regQ [REG_CNT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) regQ[i] <= '0;
    end else if (wrEn && wrAddr != '0) begin
      regQ[wrAddr] <= wrData;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : gRead
    assign rdData[p] = (rdAddr[p] == '0) ? '0 : regQ[rdAddr[p]];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> regQ[$past(wrAddr)] == $past(wrData)); // R10

  AST_ZERO_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrAddr != '0); // R4

endmodule

// File: rtl/execControl.sv
module execControl
  import execPkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              instrValid,
  input  logic [5:0]        opcode,
  input  logic [5:0]        funct,
  input  logic [REG_AW-1:0] rtIdx,
  input  logic [REG_AW-1:0] rdIdx,
  output ctrlStrobesT       ctrl,
  output logic [REG_AW-1:0] destIdx,
  output logic              illegal
);

  ctrlStrobesT raw;
  logic writeReq;
  logic badCode;
  logic destRt;

  always_comb begin
    raw      = '0;
    raw.aluOp = ALU_ADD;
    writeReq = 1'b0;
    badCode  = 1'b0;
    destRt   = 1'b0;
    case (opcode)
      OPC_REG: begin
        writeReq = 1'b1;
        case (funct)
          FN_ADD:  raw.aluOp = ALU_ADD;
          FN_SUB:  raw.aluOp = ALU_SUB;
          FN_AND:  raw.aluOp = ALU_AND;
          FN_OR:   raw.aluOp = ALU_OR;
          FN_NOR:  raw.aluOp = ALU_NOR;
          FN_SLT:  raw.aluOp = ALU_SLT;
          FN_SLTU: raw.aluOp = ALU_SLTU;
          FN_SLL:  raw.aluOp = ALU_SLL;
          FN_SRL:  raw.aluOp = ALU_SRL;
          default: badCode = 1'b1;
        endcase
      end
      OPC_BEQ: raw.isBranch = 1'b1;
      OPC_BNE: begin
        raw.isBranch = 1'b1;
        raw.branchNe = 1'b1;
      end
      OPC_ADDI: begin
        writeReq = 1'b1; destRt = 1'b1; raw.useImm = 1'b1;
        raw.aluOp = ALU_ADD;
      end
      OPC_SLTI: begin
        writeReq = 1'b1; destRt = 1'b1; raw.useImm = 1'b1;
        raw.aluOp = ALU_SLT;
      end
      OPC_SLTIU: begin
        writeReq = 1'b1; destRt = 1'b1; raw.useImm = 1'b1;
        raw.aluOp = ALU_SLTU;
      end
      OPC_ANDI: begin
        writeReq = 1'b1; destRt = 1'b1; raw.useImm = 1'b1;
        raw.immZero = 1'b1; raw.aluOp = ALU_AND;
      end
      OPC_ORI: begin
        writeReq = 1'b1; destRt = 1'b1; raw.useImm = 1'b1;
        raw.immZero = 1'b1; raw.aluOp = ALU_OR;
      end
      default: badCode = 1'b1;
    endcase
  end

  always_comb begin
    destIdx       = destRt ? rtIdx : rdIdx;
    illegal       = instrValid & badCode;
    ctrl          = raw;
    ctrl.regWrite = instrValid & writeReq & ~badCode & (destIdx != '0);
    ctrl.isBranch = instrValid & raw.isBranch;
  end

endmodule

// File: rtl/execDatapath.sv
module execDatapath
  import execPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int REG_AW = $clog2(REG_CNT),
  localparam int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       ctrl,
  input  logic [REG_AW-1:0] rsIdx,
  input  logic [REG_AW-1:0] rtIdx,
  input  logic [REG_AW-1:0] destIdx,
  input  logic [4:0]        shamt,
  input  logic [IMM_W-1:0]  imm16,
  output logic              branchTaken,
  output logic              wbEn,
  output logic [REG_AW-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);

  logic [1:0][REG_AW-1:0] rdAddr;
  logic [1:0][DATA_W-1:0] rdData;
  logic [DATA_W-1:0] opA, rtVal, opB, immExt, aluOut;

  assign rdAddr[0] = rsIdx;
  assign rdAddr[1] = rtIdx;

  execRegFile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT), .RD_PORTS(2)) uRegs (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wbEn),
    .wrAddr(wbAddr),
    .wrData(wbData),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );

  assign opA    = rdData[0];
  assign rtVal  = rdData[1];
  assign immExt = ctrl.immZero ? {{(DATA_W-IMM_W){1'b0}}, imm16}
                               : {{(DATA_W-IMM_W){imm16[IMM_W-1]}}, imm16};
  assign opB    = ctrl.useImm ? immExt : rtVal;

  always_comb begin
    case (ctrl.aluOp)
      ALU_ADD:  aluOut = opA + opB;
      ALU_SUB:  aluOut = opA - opB;
      ALU_AND:  aluOut = opA & opB;
      ALU_OR:   aluOut = opA | opB;
      ALU_NOR:  aluOut = ~(opA | opB);
      ALU_SLT:  aluOut = {{(DATA_W-1){1'b0}}, $signed(opA) < $signed(opB)};
      ALU_SLTU: aluOut = {{(DATA_W-1){1'b0}}, opA < opB};
      ALU_SLL:  aluOut = rtVal << shamt;
      ALU_SRL:  aluOut = rtVal >> shamt;
      default:  aluOut = '0;
    endcase
  end

  assign branchTaken = ctrl.isBranch & (ctrl.branchNe ? (opA != rtVal) : (opA == rtVal));
  assign wbEn   = ctrl.regWrite;
  assign wbAddr = destIdx;
  assign wbData = aluOut;

  AST_SLT_IS_BOOL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.aluOp == ALU_SLT || ctrl.aluOp == ALU_SLTU) |-> wbData[DATA_W-1:1] == '0); // R5

  AST_SRL_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.aluOp == ALU_SRL && shamt != 5'd0) |-> !wbData[DATA_W-1]); // R6

  AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> !wbEn); // R7

endmodule

// File: rtl/intExecUnit.sv
module intExecUnit
  import execPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int REG_AW = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [31:0]       instrWord,
  output logic              branchTaken,
  output logic              illegalInstr,
  output logic              wbEn,
  output logic [REG_AW-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);

  ctrlStrobesT ctrl;
  logic [REG_AW-1:0] destIdx;

  execControl #(.REG_AW(REG_AW)) uCtrl (
    .instrValid(instrValid),
    .opcode    (instrWord[31:26]),
    .funct     (instrWord[5:0]),
    .rtIdx     (instrWord[16 +: REG_AW]),
    .rdIdx     (instrWord[11 +: REG_AW]),
    .ctrl      (ctrl),
    .destIdx   (destIdx),
    .illegal   (illegalInstr)
  );

  execDatapath #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .rsIdx      (instrWord[21 +: REG_AW]),
    .rtIdx      (instrWord[16 +: REG_AW]),
    .destIdx    (destIdx),
    .shamt      (instrWord[10:6]),
    .imm16      (instrWord[15:0]),
    .branchTaken(branchTaken),
    .wbEn       (wbEn),
    .wbAddr     (wbAddr),
    .wbData     (wbData)
  );

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    illegalInstr |-> (!wbEn && !branchTaken)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> (!wbEn && !branchTaken && !illegalInstr)); // R9

endmodule

// File: tb/intExecUnit_test.sv
module intExecUnit_test;

  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic branchTaken, illegalInstr, wbEn;
  logic [4:0] wbAddr;
  logic [31:0] wbData;

  intExecUnit uut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .branchTaken(branchTaken), .illegalInstr(illegalInstr),
    .wbEn(wbEn), .wbAddr(wbAddr), .wbData(wbData)
  );

  always #(PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] model [32];
  logic capBr, capIll, capWe;
  logic [4:0] capAddr;
  logic [31:0] capData;

  function automatic logic [31:0] rType(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                        logic [4:0] sh, logic [5:0] fn);
    return {6'd0, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] iType(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                        logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // execute one word and compare against the behavioural model
  task automatic run(logic [31:0] w, string tag);
    logic [5:0] op, fn;
    logic [4:0] rs, rt, rd, sh, dst;
    logic [31:0] a, b, simm, zimm, res;
    bit eIll, eBr, isBr, eWe;
    @(negedge clk);
    instrWord = w;
    instrValid = 1'b1;
    #1;
    op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11]; sh = w[10:6]; fn = w[5:0];
    a = model[rs]; b = model[rt];
    simm = {{16{w[15]}}, w[15:0]};
    zimm = {16'd0, w[15:0]};
    eIll = 0; eBr = 0; isBr = 0; res = '0; dst = rt;
    case (op)
      6'd0: begin
        dst = rd;
        case (fn)
          6'd32: res = a + b;
          6'd34: res = a - b;
          6'd36: res = a & b;
          6'd37: res = a | b;
          6'd39: res = ~(a | b);
          6'd42: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          6'd43: res = (a < b) ? 32'd1 : 32'd0;
          6'd0:  res = b << sh;
          6'd2:  res = b >> sh;
          default: eIll = 1;
        endcase
      end
      6'd4: begin isBr = 1; eBr = (a == b); end
      6'd5: begin isBr = 1; eBr = (a != b); end
      6'd8:  res = a + simm;
      6'd10: res = ($signed(a) < $signed(simm)) ? 32'd1 : 32'd0;
      6'd11: res = (a < simm) ? 32'd1 : 32'd0;
      6'd12: res = a & zimm;
      6'd13: res = a | zimm;
      default: eIll = 1;
    endcase
    eWe = !eIll && !isBr && (dst != 5'd0);
    capBr = branchTaken; capIll = illegalInstr; capWe = wbEn;
    capAddr = wbAddr; capData = wbData;
    checkVal({tag, " branch"}, {31'd0, capBr}, {31'd0, eBr});
    checkVal({tag, " illegal"}, {31'd0, capIll}, {31'd0, eIll});
    checkVal({tag, " wbEn"}, {31'd0, capWe}, {31'd0, eWe});
    if (eWe) checkVal({tag, " wbAddr"}, {27'd0, capAddr}, {27'd0, dst});
    if (!eIll && !isBr) checkVal({tag, " wbData"}, capData, res);
    @(posedge clk);
    if (eWe) model[dst] = res;
  endtask

  // bring a register out through the result bus without changing state
  task automatic readReg(logic [4:0] idx, logic [31:0] exp, string tag);
    run(rType(idx, 5'd0, 5'd0, 5'd0, 6'd37), tag);
    checkVal({tag, " readback"}, capData, exp);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    instrValid = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    #1;
    checkVal("R9 idle branch", {31'd0, branchTaken}, 32'd0);
    checkVal("R9 idle illegal", {31'd0, illegalInstr}, 32'd0);
    checkVal("R9 idle wbEn", {31'd0, wbEn}, 32'd0);
    rstN = 1'b1;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    readReg(5'd5, 32'd0, "R9 reg cleared");

    // R3 sign-extended immediates
    run(iType(6'd8, 5'd0, 5'd17, 16'h7FFF), "R3 addi pos");
    checkVal("R3 addi pos value", capData, 32'h0000_7FFF);
    run(iType(6'd8, 5'd0, 5'd18, 16'hFFFF), "R3 addi neg");
    checkVal("R3 addi sign-ext", capData, 32'hFFFF_FFFF);

    // R1 encoded add example
    run(32'h0232_4020, "R1 add word");
    checkVal("R1 add value", capData, 32'h0000_7FFE);
    checkVal("R1 add dest", {27'd0, capAddr}, 32'd8);

    // R10 back-to-back dependency, R6 shifts
    run(iType(6'd8, 5'd0, 5'd1, 16'h8000), "R3 addi min");
    run(rType(5'd0, 5'd1, 5'd2, 5'd16, 6'd0), "R10 sll uses fresh r1");
    checkVal("R6 sll 16", capData, 32'h8000_0000);
    run(rType(5'd0, 5'd2, 5'd3, 5'd31, 6'd2), "R6 srl 31");
    checkVal("R6 srl zero fill", capData, 32'h0000_0001);
    run(rType(5'd0, 5'd18, 5'd4, 5'd0, 6'd0), "R6 sll 0");
    checkVal("R6 shamt zero", capData, 32'hFFFF_FFFF);

    // R1 wrapping
    run(rType(5'd2, 5'd3, 5'd5, 5'd0, 6'd34), "R1 sub wrap");
    checkVal("R1 sub value", capData, 32'h7FFF_FFFF);
    run(rType(5'd5, 5'd3, 5'd6, 5'd0, 6'd32), "R1 add wrap");
    checkVal("R1 add overflow wraps", capData, 32'h8000_0000);

    // R2 logic
    run(rType(5'd17, 5'd1, 5'd7, 5'd0, 6'd36), "R2 and");
    checkVal("R2 and value", capData, 32'h0000_0000);
    run(rType(5'd17, 5'd1, 5'd7, 5'd0, 6'd37), "R2 or");
    checkVal("R2 or value", capData, 32'hFFFF_FFFF);
    run(rType(5'd17, 5'd0, 5'd9, 5'd0, 6'd39), "R2 not via nor");
    checkVal("R2 not value", capData, 32'hFFFF_8000);

    // R3 zero-extended immediates
    run(iType(6'd12, 5'd18, 5'd10, 16'h8001), "R3 andi");
    checkVal("R3 andi zero-ext", capData, 32'h0000_8001);
    run(iType(6'd13, 5'd0, 5'd11, 16'hFFFF), "R3 ori");
    checkVal("R3 ori zero-ext", capData, 32'h0000_FFFF);

    // R5 compares
    run(rType(5'd18, 5'd3, 5'd12, 5'd0, 6'd42), "R5 slt");
    checkVal("R5 slt -1<1", capData, 32'd1);
    run(rType(5'd18, 5'd3, 5'd13, 5'd0, 6'd43), "R5 sltu");
    checkVal("R5 sltu big<1", capData, 32'd0);
    run(rType(5'd3, 5'd18, 5'd12, 5'd0, 6'd42), "R5 slt rev");
    checkVal("R5 slt 1<-1", capData, 32'd0);
    run(iType(6'd10, 5'd18, 5'd14, 16'h0001), "R5 slti");
    checkVal("R5 slti value", capData, 32'd1);
    run(iType(6'd11, 5'd3, 5'd15, 16'hFFFF), "R5 sltiu");
    checkVal("R5 sltiu value", capData, 32'd1);

    // R4 register zero
    run(iType(6'd8, 5'd0, 5'd0, 16'h0005), "R4 write r0");
    checkVal("R4 no wbEn", {31'd0, capWe}, 32'd0);
    readReg(5'd0, 32'd0, "R4 r0 reads zero");

    // R7 branches
    run(iType(6'd4, 5'd17, 5'd17, 16'h0010), "R7 beq equal");
    checkVal("R7 beq taken", {31'd0, capBr}, 32'd1);
    checkVal("R7 beq no write", {31'd0, capWe}, 32'd0);
    run(iType(6'd4, 5'd17, 5'd18, 16'h0010), "R7 beq differ");
    checkVal("R7 beq not taken", {31'd0, capBr}, 32'd0);
    run(iType(6'd5, 5'd17, 5'd18, 16'h0010), "R7 bne differ");
    checkVal("R7 bne taken", {31'd0, capBr}, 32'd1);
    run(iType(6'd5, 5'd3, 5'd3, 16'h0010), "R7 bne equal");
    checkVal("R7 bne not taken", {31'd0, capBr}, 32'd0);
    readReg(5'd17, 32'h0000_7FFF, "R7 rt untouched");

    // R8 illegal words
    run(rType(5'd1, 5'd1, 5'd17, 5'd0, 6'd33), "R8 bad funct");
    checkVal("R8 bad funct flag", {31'd0, capIll}, 32'd1);
    readReg(5'd17, 32'h0000_7FFF, "R8 dest unchanged");
    run(iType(6'd63, 5'd1, 5'd17, 16'h1234), "R8 bad opcode");
    checkVal("R8 bad opcode flag", {31'd0, capIll}, 32'd1);
    run(iType(6'd2, 5'd1, 5'd17, 16'h1234), "R8 jump opcode");
    readReg(5'd17, 32'h0000_7FFF, "R8 dest still unchanged");

    // R10 random sequence against the model
    for (int n = 0; n < 400; n++) begin
      logic [5:0] ops [8];
      logic [5:0] fns [9];
      logic [31:0] w;
      ops = '{6'd0, 6'd4, 6'd5, 6'd8, 6'd10, 6'd11, 6'd12, 6'd13};
      fns = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd39, 6'd42, 6'd43, 6'd0, 6'd2};
      w = $urandom;
      w[25:21] = w[25:21] & 5'd7;
      w[20:16] = w[20:16] & 5'd7;
      w[15:11] = w[15:11] & 5'd7;
      if ($urandom_range(0, 15) != 0) begin
        w[31:26] = ops[$urandom_range(0, 7)];
        if (w[31:26] == 6'd0) w[5:0] = fns[$urandom_range(0, 8)];
      end
      run(w, "R10 random");
    end

    // R9 reset clears state mid-run
    doReset();
    readReg(5'd17, 32'd0, "R9 reset clears r17");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule